// File: doc/BRIEF.md
# CPU Initial Reset Generator

This block produces the initial reset for a small CPU core from three independent causes. The first is power-up: reset is held until the oscillator reports that it is running. The second is an active-high reset pin. The third is a key-chord detector on a 4-bit input port, which fires when a chosen group of port bits has been high together for a long noise-rejection interval. A static 2-bit option picks the group, or turns the chord path off.

The reset output is the OR of the three causes. It rises at once while the oscillator is not ready. Every release is retimed to the clock through a short pipeline. The pin and the port bits each pass through a two-flop synchronizer before any logic uses them.

While reset is high, the block also presents the program-counter start values to the core: step 00h and page 1h.

Top module: `init_reset_ctrl`

## Requirements
- R1: While `oscReady` is low, `cpuReset` is high without waiting for a clock edge, and `pcStep` = 8'h00 and `pcPage` = 4'h1.
- R2: After `oscReady` rises with no other cause active, `cpuReset` falls on the second rising clock edge.
- R3: A high `resetPin` raises `cpuReset` on the fourth rising edge after it goes high, keeps it high while the pin stays high, and releases it on the fourth rising edge after the pin goes low.
- R4: `keyOpt` selects the chord: 0 = none, 1 = bits 0 and 1, 2 = bits 0, 1 and 2, 3 = all four bits. Port bits outside the selected group have no effect.
- R5: When every selected bit has been high for `HOLD_CYCLES` consecutive sampled edges, `cpuReset` rises on rising edge `HOLD_CYCLES`+4, counting the first edge that samples the full chord as edge 1.
- R6: A chord that lasts fewer than `HOLD_CYCLES` sampled edges causes no reset. Any selected bit going low restarts the count from zero.
- R7: Once the chord has caused a reset, `cpuReset` stays high while the chord is held. It falls on the fifth rising edge after any selected bit goes low.
- R8: With `keyOpt` = 0, no port pattern of any length causes a reset.
- R9: While `cpuReset` is low, `pcStep` and `pcPage` are both zero. While it is high, they are 8'h00 and 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| oscReady | input | 1 | High once the oscillator is running; low means power-up reset |
| resetPin | input | 1 | External reset request, active high, asynchronous |
| keyPort | input | 4 | Input-port bits watched by the chord detector, asynchronous |
| keyOpt | input | 2 | Static chord select (0 off, 1 two bits, 2 three bits, 3 four bits) |
| cpuReset | output | 1 | Initial reset to the CPU, active high |
| pcStep | output | 8 | Program-counter step start value, valid while reset is high |
| pcPage | output | 4 | Program-counter page start value, valid while reset is high |

## Verification
A hold counter left non-zero, or one that fails to clear, shows up as a reset that fires early after a burst of short glitches. It shows at the output the first time a chord shorter than the threshold is applied. A wrong option decode shows within `HOLD_CYCLES`+4 edges of a chord that either should or should not fire. A wrong length in the synchronizer or release pipeline moves every edge of `cpuReset` by a whole cycle. The cycle-accurate comparison catches this on the very first pin pulse.

// File: rtl/init_reset_pkg.sv
package init_reset_pkg;

  localparam int KEY_W = 4;

  typedef enum logic [1:0] {
    KEY_OFF  = 2'd0,
    KEY_PAIR = 2'd1,
    KEY_TRIO = 2'd2,
    KEY_ALL  = 2'd3
  } keyOpt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;   // chord broken: restart the hold count
    logic holdInc;   // chord present: advance the hold count
    logic relReq;    // a synchronous reset cause is active
  } rstStrobe_t;

  function automatic logic [KEY_W-1:0] chordMask(keyOpt_e opt);
    case (opt)
      KEY_PAIR: return 4'b0011;
      KEY_TRIO: return 4'b0111;
      KEY_ALL:  return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/init_reset_sync.sv
module init_reset_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/init_reset_ctl.sv
module init_reset_ctl
  import init_reset_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             resetPin,
  input  logic [KEY_W-1:0] keyPort,
  input  logic [1:0]       keyOpt,
  input  logic             keyHit,
  output rstStrobe_t       strobe
);

  logic             pinSync;
  logic [KEY_W-1:0] keySync;
  logic [KEY_W-1:0] selMask;
  logic [KEY_W-1:0] bitOk;
  logic             chordOn;

  init_reset_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) pinSyncInst (
    .clk(clk), .clr(por), .din(resetPin), .dout(pinSync)
  );

  init_reset_sync #(.WIDTH(KEY_W), .STAGES(SYNC_STAGES)) keySyncInst (
    .clk(clk), .clr(por), .din(keyPort), .dout(keySync)
  );

  assign selMask = chordMask(keyOpt_e'(keyOpt));

  // a bit is satisfied when it is not selected or when it is high
  for (genvar b = 0; b < KEY_W; b++) begin : gBitOk
    assign bitOk[b] = ~selMask[b] | keySync[b];
  end

  assign chordOn = (|selMask) & (&bitOk);

  always_comb begin
    strobe.holdClr = ~chordOn;
    strobe.holdInc = chordOn;
    strobe.relReq  = pinSync | keyHit;
  end

endmodule

// File: rtl/init_reset_dp.sv
module init_reset_dp
  import init_reset_pkg::*;
#(
  parameter int HOLD_CYCLES = 2_000_000,
  parameter int REL_STAGES  = 2,
  parameter int STEP_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int STEP_INIT   = 0,
  parameter int PAGE_INIT   = 1
) (
  input  logic              clk,
  input  logic              por,
  input  rstStrobe_t        strobe,
  output logic              keyHit,
  output logic              cpuReset,
  output logic [STEP_W-1:0] pcStep,
  output logic [PAGE_W-1:0] pcPage
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0]      holdCnt;
  logic [REL_STAGES-1:0] relPipe;

  // continuous-hold counter, saturating at the threshold
  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      holdCnt <= '0;
    end else if (strobe.holdClr) begin
      holdCnt <= '0;
    end else if (strobe.holdInc && holdCnt != CNT_TOP) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign keyHit = (holdCnt == CNT_TOP);

  // asynchronous assertion, clock-retimed release
  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      relPipe <= '1;
    end else begin
      relPipe <= {relPipe[REL_STAGES-2:0], strobe.relReq};
    end
  end

  assign cpuReset = relPipe[REL_STAGES-1];
  assign pcStep   = cpuReset ? STEP_W'(STEP_INIT) : '0;
  assign pcPage   = cpuReset ? PAGE_W'(PAGE_INIT) : '0;

endmodule

// File: rtl/init_reset_ctrl.sv
module init_reset_ctrl
  import init_reset_pkg::*;
#(
  parameter int HOLD_CYCLES = 2_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int REL_STAGES  = 2,
  parameter int STEP_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int STEP_INIT   = 0,
  parameter int PAGE_INIT   = 1
) (
  input  logic              clk,
  input  logic              oscReady,
  input  logic              resetPin,
  input  logic [KEY_W-1:0]  keyPort,
  input  logic [1:0]        keyOpt,
  output logic              cpuReset,
  output logic [STEP_W-1:0] pcStep,
  output logic [PAGE_W-1:0] pcPage
);

  logic       por;
  logic       keyHit;
  rstStrobe_t strobe;

  assign por = ~oscReady;

  init_reset_ctl #(.SYNC_STAGES(SYNC_STAGES)) ctlInst (
    .clk(clk), .por(por), .resetPin(resetPin), .keyPort(keyPort),
    .keyOpt(keyOpt), .keyHit(keyHit), .strobe(strobe)
  );

  init_reset_dp #(
    .HOLD_CYCLES(HOLD_CYCLES), .REL_STAGES(REL_STAGES),
    .STEP_W(STEP_W), .PAGE_W(PAGE_W),
    .STEP_INIT(STEP_INIT), .PAGE_INIT(PAGE_INIT)
  ) dpInst (
    .clk(clk), .por(por), .strobe(strobe), .keyHit(keyHit),
    .cpuReset(cpuReset), .pcStep(pcStep), .pcPage(pcPage)
  );

endmodule

// File: rtl/init_reset_chk.sv
module init_reset_chk
  import init_reset_pkg::*;
#(
  parameter int HOLD_CYCLES = 2_000_000
) (
  input logic             clk,
  input logic             oscReady,
  input logic             resetPin,
  input logic [KEY_W-1:0] keyPort,
  input logic [1:0]       keyOpt,
  input logic             cpuReset,
  input logic             keyHit
);

  int unsigned upCnt;
  int unsigned runLen;
  int unsigned offLen;
  logic [KEY_W-1:0] m;
  logic chordPort;

  assign m = chordMask(keyOpt_e'(keyOpt));
  assign chordPort = (m != '0) && ((keyPort & m) == m);

  always_ff @(posedge clk or negedge oscReady) begin
    if (!oscReady) begin
      upCnt  <= 0;
      runLen <= 0;
      offLen <= 0;
    end else begin
      if (upCnt < 8) upCnt <= upCnt + 1;
      if (!chordPort) runLen <= 0;
      else if (runLen < HOLD_CYCLES + 4) runLen <= runLen + 1;
      if (keyOpt != 2'd0) offLen <= 0;
      else if (offLen < 4) offLen <= offLen + 1;
    end
  end

  always @(negedge clk) begin
    if (oscReady === 1'b0) AST_POR_HOLDS: assert (cpuReset === 1'b1); // R1
  end

  AST_PIN_ASSERTS: assert property (@(posedge clk) disable iff (!oscReady)
    (upCnt >= 5 && $past(resetPin, 1) && $past(resetPin, 2) &&
     $past(resetPin, 3) && $past(resetPin, 4)) |-> cpuReset); // R3

  AST_FALL_NEEDS_PIN_LOW: assert property (@(posedge clk) disable iff (!oscReady)
    (upCnt >= 2 && $fell(cpuReset)) |-> !$past(resetPin)); // R3

  AST_HOLD_BEFORE_HIT: assert property (@(posedge clk) disable iff (!oscReady)
    (upCnt >= 2 && $rose(keyHit)) |-> (runLen >= HOLD_CYCLES)); // R6

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!oscReady)
    (offLen >= 2) |-> !keyHit); // R8

endmodule

bind init_reset_ctrl init_reset_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chkInst (
  .clk(clk), .oscReady(oscReady), .resetPin(resetPin), .keyPort(keyPort),
  .keyOpt(keyOpt), .cpuReset(cpuReset), .keyHit(keyHit)
);

// File: tb/init_reset_ctrl_test.sv
module init_reset_ctrl_test;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       oscReady = 1'b0;
  logic       resetPin = 1'b0;
  logic [3:0] keyPort = 4'h0;
  logic [1:0] keyOpt = 2'd3;
  logic       cpuReset;
  logic [7:0] pcStep;
  logic [3:0] pcPage;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  bit [3:0] keyQ[$] = '{4'h0, 4'h0};
  bit       pinQ[$] = '{1'b0, 1'b0};
  bit       relQ[$] = '{1'b1, 1'b1};
  int       holdM = 0;

  init_reset_ctrl #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .oscReady(oscReady), .resetPin(resetPin), .keyPort(keyPort),
    .keyOpt(keyOpt), .cpuReset(cpuReset), .pcStep(pcStep), .pcPage(pcPage)
  );

  always #4 clk = ~clk;

  function automatic bit [3:0] maskOf(bit [1:0] o);
    case (o)
      2'd1: return 4'h3;
      2'd2: return 4'h7;
      2'd3: return 4'hF;
      default: return 4'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!oscReady) begin
      keyQ = '{4'h0, 4'h0};
      pinQ = '{1'b0, 1'b0};
      relQ = '{1'b1, 1'b1};
      holdM = 0;
    end else begin
      bit [3:0] mk;
      bit chord;
      bit hitOld;
      mk = maskOf(keyOpt);
      chord = (mk != 0) && ((keyQ[0] & mk) == mk);
      hitOld = (holdM >= HOLD);
      relQ.push_back(pinQ[0] | hitOld);
      void'(relQ.pop_front());
      holdM = chord ? ((holdM + 1 > HOLD) ? HOLD : holdM + 1) : 0;
      keyQ.push_back(keyPort);
      void'(keyQ.pop_front());
      pinQ.push_back(resetPin);
      void'(pinQ.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit expRst;
      expRst = !oscReady ? 1'b1 : relQ[0];
      vectors++;
      if (cpuReset !== expRst) begin
        misses++;
        $display("FAIL %s cpuReset at cycle %0d: got %b expected %b", curReq, cycles, cpuReset, expRst);
      end
      vectors++;
      if (pcStep !== (expRst ? 8'h00 : 8'h00) || pcPage !== (expRst ? 4'h1 : 4'h0)) begin
        misses++;
        $display("FAIL R9 pc vector at cycle %0d: got %h/%h expected %h/%h", cycles,
                 pcStep, pcPage, 8'h00, expRst ? 4'h1 : 4'h0);
      end
      if (cycles > 50000) begin
        misses++;
        $display("FAIL watchdog expired at cycle %0d: got running expected finished", cycles);
        finish();
      end
    end
  end

  task automatic finish();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chord(bit [1:0] opt, bit [3:0] pat, int len, int gap);
    keyOpt = opt;
    keyPort = pat;
    cyc(len);
    keyPort = 4'h0;
    cyc(gap);
  endtask

  initial begin
    // R1: power-up reset and start vector
    curReq = "R1";
    cyc(5);
    // R2: release after oscillator ready
    curReq = "R2";
    oscReady = 1'b1;
    cyc(6);
    // R3: pin reset, assert and release timing
    curReq = "R3";
    resetPin = 1'b1;
    cyc(7);
    resetPin = 1'b0;
    cyc(7);
    resetPin = 1'b1;
    cyc(1);
    resetPin = 1'b0;
    cyc(6);
    // R5, R7: full chord held past the threshold, then released
    curReq = "R5";
    keyOpt = 2'd3;
    keyPort = 4'hF;
    cyc(HOLD + 4);
    curReq = "R7";
    cyc(5);
    keyPort = 4'h7;
    cyc(8);
    keyPort = 4'h0;
    cyc(4);
    // R6: runs one short of the threshold, and a dropped bit mid-run
    curReq = "R6";
    chord(2'd3, 4'hF, HOLD - 1, 1);
    chord(2'd3, 4'hF, HOLD - 1, 3);
    keyPort = 4'hF;
    cyc(HOLD - 2);
    keyPort = 4'hB;
    cyc(1);
    keyPort = 4'hF;
    cyc(HOLD - 1);
    keyPort = 4'h0;
    cyc(6);
    // R4: each option responds only to its own chord
    curReq = "R4";
    chord(2'd1, 4'h3, HOLD + 6, 8);
    chord(2'd1, 4'hC, HOLD + 6, 8);
    chord(2'd1, 4'hB, HOLD + 6, 8);
    chord(2'd2, 4'h3, HOLD + 6, 8);
    chord(2'd2, 4'h7, HOLD + 6, 8);
    chord(2'd3, 4'h7, HOLD + 6, 8);
    chord(2'd3, 4'hE, HOLD + 6, 8);
    // R8: option off ignores every pattern
    curReq = "R8";
    chord(2'd0, 4'hF, 3 * HOLD, 4);
    chord(2'd0, 4'h3, 3 * HOLD, 4);
    // R1 again: power drop mid-run asserts at once
    curReq = "R1";
    keyOpt = 2'd3;
    keyPort = 4'hF;
    cyc(3);
    oscReady = 1'b0;
    cyc(4);
    keyPort = 4'h0;
    curReq = "R2";
    oscReady = 1'b1;
    cyc(6);
    finish();
  end

endmodule